// File: doc/BRIEF.md
# Segmented Pulse-Width Precharge Timer

This block turns a 6-bit unsigned code into a single enable pulse whose length in clock ticks equals the code value. The pulse gates a constant-current source that precharges a bit line, so the charge delivered is proportional to the code. Charging takes place in two halves of a fixed frame. In the first half (the coarse half) the upper three code bits set the width. In the second half (the fine half) the lower three bits set it. One bank of eight timing waveforms and one 8:1 selector are shared by both halves. The coarse pulse is aligned to end on the last coarse tick and the fine pulse starts on the first fine tick, so the two pieces always join into one unbroken pulse.

The frame is a four-state machine. `ST_IDLE` waits for `start`. On `start`, the transition IDLE→COARSE latches the code, with the LSB cleared when `half_res` is high. `ST_COARSE` lasts 56 ticks with `phase_hi` high, and its last tick takes COARSE→FINE. `ST_FINE` lasts 7 ticks, and its last tick takes FINE→DONE. `ST_DONE` lasts one tick with `done` high, then takes DONE→IDLE. A full frame is therefore 56 + 7 ticks followed by the done tick.

Top module: `pwdac_pulse_gen`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `on`, `phase_hi` and `done` are all 0. A reset in mid-frame abandons the frame.
- R2: A `start` seen in idle begins a frame on the next cycle. `phase_hi` is high for exactly 56 cycles, then low for exactly 7 cycles, then `done` is high for exactly one cycle.
- R3: Within a frame, the number of cycles with `on` high equals the latched code.
- R4: `on` rises at most once per frame, and exactly once for a nonzero code.
- R5: While `phase_hi` is high, `on` is high for 8 × code[5:3] cycles. For a nonzero upper field, `on` is high on the last `phase_hi` cycle.
- R6: While `phase_hi` is low in the frame, `on` is high for code[2:0] cycles. For a nonzero lower field, `on` is high on the first such cycle.
- R7: When `half_res` is 1 at `start`, code bit 0 is treated as 0 (for example, code 63 gives a 62-cycle pulse).
- R8: `start`, `code` and `half_res` have no effect while a frame is in progress. The running frame keeps its length and pulse, and no second frame follows.
- R9: Code 0 produces no `on` cycle, but the frame still runs its full length and raises `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a frame when the block is idle |
| code | input | 6 | Unsigned pulse-length code |
| half_res | input | 1 | Reduced-resolution mode: clears code bit 0 at latch time |
| on | output | 1 | Precharge enable pulse |
| phase_hi | output | 1 | High during the coarse half of the frame |
| done | output | 1 | One-cycle flag at the end of the frame |

## Verification
The condition that is hardest to reach is a request that arrives while a frame is running. The output shows only a pulse count, so a design that re-latched the code or restarted the frame could still look plausible. The bench reaches this case by pulsing `start` twenty cycles into a frame, with a different code and the opposite mode. It then checks the pulse count, the length of each half and the single `done`, and it watches a further 70 cycles for any second frame. A reset applied mid-frame, and a full sweep of all codes in both modes, cover the joins between the coarse and fine pulses.

// File: rtl/pwdac_pkg.sv
package pwdac_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COARSE = 2'd1,
        ST_FINE   = 2'd2,
        ST_DONE   = 2'd3
    } pwdac_state_e;
endpackage

// File: rtl/pwdac_tick_counter.sv
module pwdac_tick_counter #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             en,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (clear)
            count <= '0;
        else if (en)
            count <= count + CNT_W'(1);
    end
endmodule

// File: rtl/pwdac_timing_bank.sv
// Eight (2**SEG_W) shared timing waveforms. Waveform k covers the last
// NSEL*k ticks of the coarse half and the first k ticks of the fine half.
module pwdac_timing_bank #(
    parameter int SEG_W = 3,
    parameter int CNT_W = 6,
    localparam int NSEL = 1 << SEG_W,
    localparam int COARSE_LEN = NSEL * (NSEL - 1)
) (
    input  logic             phase_hi,
    input  logic [CNT_W-1:0] tick,
    output logic [NSEL-1:0]  tsig
);
    for (genvar k = 0; k < NSEL; k++) begin : g_wave
        always_comb begin
            if (phase_hi)
                tsig[k] = int'(tick) >= (COARSE_LEN - NSEL * k);
            else
                tsig[k] = int'(tick) < k;
        end
    end
endmodule

// File: rtl/pwdac_sel_mux.sv
// The single selector shared by both halves of the frame.
module pwdac_sel_mux #(
    parameter int SEG_W = 3,
    localparam int NSEL = 1 << SEG_W
) (
    input  logic [NSEL-1:0]  tsig,
    input  logic [SEG_W-1:0] sel,
    output logic             y
);
    always_comb y = tsig[sel];
endmodule

// File: rtl/pwdac_pulse_gen.sv
module pwdac_pulse_gen
    import pwdac_pkg::*;
#(
    parameter int CODE_W = 6,
    localparam int SEG_W = CODE_W / 2,
    localparam int NSEL = 1 << SEG_W,
    localparam int COARSE_LEN = NSEL * (NSEL - 1),
    localparam int FINE_LEN = NSEL - 1,
    localparam int CNT_W = $clog2(COARSE_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CODE_W-1:0] code,
    input  logic              half_res,
    output logic              on,
    output logic              phase_hi,
    output logic              done
);
    pwdac_state_e      state_q, state_d;
    logic [CODE_W-1:0] code_q;
    logic [CNT_W-1:0]  tick;
    logic [NSEL-1:0]   tsig;
    logic [SEG_W-1:0]  sel;
    logic              mux_y;
    logic              in_frame;
    logic              accept;

    assign accept = (state_q == ST_IDLE) && start;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_COARSE;
            ST_COARSE: if (tick == CNT_W'(COARSE_LEN - 1)) state_d = ST_FINE;
            ST_FINE:   if (tick == CNT_W'(FINE_LEN - 1)) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
        endcase
    end

    // Code latch: loaded only in idle, held for the whole frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            code_q <= '0;
        else if (accept)
            code_q <= code & ~{{(CODE_W-1){1'b0}}, half_res};
    end

    pwdac_tick_counter #(.CNT_W(CNT_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_d != state_q),
        .en    (in_frame),
        .count (tick)
    );

    pwdac_timing_bank #(.SEG_W(SEG_W), .CNT_W(CNT_W)) u_bank (
        .phase_hi (phase_hi),
        .tick     (tick),
        .tsig     (tsig)
    );

    assign sel = phase_hi ? code_q[CODE_W-1 -: SEG_W] : code_q[SEG_W-1:0];

    pwdac_sel_mux #(.SEG_W(SEG_W)) u_mux (
        .tsig (tsig),
        .sel  (sel),
        .y    (mux_y)
    );

    // Output decode
    always_comb begin
        phase_hi = 1'b0;
        in_frame = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_COARSE: begin phase_hi = 1'b1; in_frame = 1'b1; end
            ST_FINE:   in_frame = 1'b1;
            ST_DONE:   done = 1'b1;
        endcase
        on = in_frame & mux_y;
    end

    // Assertion support: per-frame pulse bookkeeping
    logic [CODE_W:0] chk_on_cnt;
    logic [1:0]      chk_rises;
    logic            chk_prev_on;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_on_cnt  <= '0;
            chk_rises   <= '0;
            chk_prev_on <= 1'b0;
        end else begin
            chk_prev_on <= on;
            if (accept) begin
                chk_on_cnt <= '0;
                chk_rises  <= '0;
            end else begin
                if (on) chk_on_cnt <= chk_on_cnt + (CODE_W+1)'(1);
                if (on && !chk_prev_on && chk_rises != 2'd3) chk_rises <= chk_rises + 2'd1;
            end
        end
    end

    a_r3_count_matches_code: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (chk_on_cnt == {1'b0, code_q}));

    a_r4_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (chk_rises <= 2'd1));

    a_r2_done_after_fine: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FINE && tick == CNT_W'(FINE_LEN - 1)) |=> done);

    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_code_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> $stable(code_q));

    a_r9_quiet_outside_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (done || state_q == ST_IDLE) |-> (!on && !phase_hi));
endmodule

// File: tb/pwdac_pulse_gen_tb.sv
module pwdac_pulse_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [5:0] code = '0;
    logic       half_res = 1'b0;
    logic       on, phase_hi, done;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pwdac_pulse_gen u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .code(code),
        .half_res(half_res), .on(on), .phase_hi(phase_hi), .done(done)
    );

    // {half_res, code, expected on-cycles}
    localparam logic [13:0] VEC [12] = '{
        {1'b0, 6'd0,  7'd0},  {1'b0, 6'd63, 7'd63}, {1'b0, 6'd24, 7'd24},
        {1'b0, 6'd7,  7'd7},  {1'b0, 6'd8,  7'd8},  {1'b0, 6'd56, 7'd56},
        {1'b0, 6'd1,  7'd1},  {1'b0, 6'd57, 7'd57}, {1'b1, 6'd63, 7'd62},
        {1'b1, 6'd1,  7'd0},  {1'b1, 6'd25, 7'd24}, {1'b0, 6'd36, 7'd36}
    };

    int r_on, r_on_hi, r_on_lo, r_rise, r_hi, r_lo;
    logic r_first_lo_on, r_last_hi_on, r_done_seen, r_done_one;

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_frame(input logic [5:0] c, input logic hr, input logic inject);
        logic prev;
        r_on = 0; r_on_hi = 0; r_on_lo = 0; r_rise = 0; r_hi = 0; r_lo = 0;
        r_first_lo_on = 0; r_last_hi_on = 0; r_done_seen = 0; r_done_one = 0;
        prev = 0;
        @(negedge clk);
        start = 1'b1; code = c; half_res = hr;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 200; i++) begin
            if (done) begin
                r_done_seen = 1;
                @(negedge clk);
                r_done_one = !done;
                break;
            end
            if (phase_hi) begin
                r_hi++;
                if (on) r_on_hi++;
                r_last_hi_on = on;
            end else begin
                if (r_lo == 0) r_first_lo_on = on;
                r_lo++;
                if (on) r_on_lo++;
            end
            if (on) r_on++;
            if (on && !prev) r_rise++;
            prev = on;
            if (inject && i == 20) begin
                start = 1'b1; code = ~c; half_res = ~hr;
            end
            if (inject && i == 21) start = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic check_frame(input logic [5:0] eff, input int exp_cnt);
        int msb, lsb;
        msb = int'(eff[5:3]); lsb = int'(eff[2:0]);
        chk(r_on == exp_cnt, "R3 on count", r_on, exp_cnt);
        chk(r_rise == (exp_cnt != 0 ? 1 : 0), "R4 rise count", r_rise, exp_cnt != 0 ? 1 : 0);
        chk(r_hi == 56, "R2 coarse length", r_hi, 56);
        chk(r_lo == 7, "R2 fine length", r_lo, 7);
        chk(r_done_seen && r_done_one, "R2 done one cycle", int'(r_done_one), 1);
        chk(r_on_hi == 8 * msb, "R5 coarse width", r_on_hi, 8 * msb);
        if (msb != 0) chk(r_last_hi_on, "R5 coarse end aligned", int'(r_last_hi_on), 1);
        chk(r_on_lo == lsb, "R6 fine width", r_on_lo, lsb);
        if (lsb != 0) chk(r_first_lo_on, "R6 fine start aligned", int'(r_first_lo_on), 1);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL R2 watchdog: actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!on && !phase_hi && !done, "R1 outputs in reset", int'({on, phase_hi, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!on && !phase_hi && !done, "R1 outputs after reset", int'({on, phase_hi, done}), 0);

        // Vector table
        foreach (VEC[i]) begin
            run_frame(VEC[i][12:7], VEC[i][13], 1'b0);
            check_frame(VEC[i][13] ? (VEC[i][12:7] & 6'h3E) : VEC[i][12:7], int'(VEC[i][6:0]));
        end

        // Full sweep, both modes (R7 for the reduced mode, R9 for code 0)
        for (int hr = 0; hr < 2; hr++) begin
            for (int c = 0; c < 64; c++) begin
                logic [5:0] eff;
                eff = (hr != 0) ? (6'(c) & 6'h3E) : 6'(c);
                run_frame(6'(c), hr[0], 1'b0);
                if (hr != 0) chk(r_on == int'(eff), "R7 reduced-mode count", r_on, int'(eff));
                check_frame(eff, int'(eff));
            end
        end

        // R9: code 0 still completes with done
        run_frame(6'd0, 1'b0, 1'b0);
        chk(r_on == 0, "R9 zero code no pulse", r_on, 0);
        chk(r_done_seen, "R9 zero code done", int'(r_done_seen), 1);

        // R8: mid-frame start and input change ignored
        run_frame(6'd5, 1'b0, 1'b1);
        check_frame(6'd5, 5);
        begin
            int extra;
            extra = 0;
            for (int i = 0; i < 70; i++) begin
                if (phase_hi || on || done) extra++;
                @(negedge clk);
            end
            chk(extra == 0, "R8 no second frame", extra, 0);
        end
        code = '0; half_res = 1'b0;

        // R1: reset in mid-frame abandons the frame
        @(negedge clk);
        start = 1'b1; code = 6'd63;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!on && !phase_hi && !done, "R1 mid-frame reset", int'({on, phase_hi, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!on && !phase_hi, "R1 idle after reset", int'({on, phase_hi}), 0);
        run_frame(6'd42, 1'b0, 1'b0);
        check_frame(6'd42, 42);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule